// File: doc/BRIEF.md
# Phase-Locked Dual-Rate Sync Burst Generator

This block drives a pair of serial bus lines, a data line and a clock line, with a single timed burst of two square waves. The data line runs at exactly twice the frequency of the clock line. Both waves come from one shared two-bit phase counter, so they cannot drift apart. A start pulse launches the burst. A programmable half-period count sets how many system-clock ticks each half period of the faster wave lasts. A programmable tick budget sets the minimum burst length.

The phase counter advances once per half period of the data line. The pair {clock, data} therefore walks through 00, 01, 10, 11 and then repeats. The burst only stops at the end of a complete clock-line period, and only once the tick budget has been used up. The last slow period is never cut short.

When the burst stops, both lines return to the released (high) level and a one-cycle completion pulse is raised. Typical use: a target device that must see, for a minimum time such as 20 ms, a faster wave on its data pin locked to a wave of half that rate on its clock pin. A 10% frequency tolerance lets the integer half-period count be rounded.

Top module: `sync_burst_gen`

## Requirements
- R1: After reset and whenever no burst is running, both line outputs are 1, `busy` is 0 and `done` is 0 (except for the completion pulse of R7).
- R2: A `start` sampled high while idle makes `busy` 1 from the next cycle on, with both lines at 0 in that first busy cycle.
- R3: During a burst with effective half-period h, busy cycle k (k = 0 at the first busy cycle) drives {line_clk, line_data} = (k / h) mod 4, using integer division. So the data line is bit 0 and the clock line is bit 1 of that count, and the clock line has half the data line's frequency.
- R4: Every change of the clock line during a burst happens in the same cycle as a change of the data line.
- R5: A `half_ticks` value of 0 behaves exactly like a value of 1.
- R6: The burst lasts L cycles, where L is the smallest positive multiple of 4h that is greater than or equal to `total_ticks`. So L is never shorter than the budget, and it is 4h when the budget is 0.
- R7: In the cycle after the last busy cycle, `busy` is 0, `done` is 1 and both lines are 1. In the cycle after that, `done` is 0 again.
- R8: A `start` during a burst is ignored. `half_ticks` and `total_ticks` are captured only when a burst starts, so changing them mid-burst does not alter the waveform or the length of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a burst when idle |
| half_ticks | input | HALF_W | System-clock ticks per half period of the data line (0 means 1) |
| total_ticks | input | TOTAL_W | Minimum burst length in system-clock ticks |
| line_data | output | 1 | Data line drive, 1 = released |
| line_clk | output | 1 | Clock line drive, 1 = released |
| busy | output | 1 | High while a burst is running |
| done | output | 1 | One-cycle pulse when a burst finishes |

## Verification
A corrupted phase counter or half-period counter shows up on the lines within one half period. The step lands late or early against the k/h schedule, or a clock-line edge appears without a matching data-line edge. A wrong elapsed count or a wrong end condition is only visible at the end of the burst, as a busy fall on the wrong cycle or a fall outside the 11 phase. The bench therefore checks every busy cycle of each burst, plus the two cycles that follow it. Re-capture of parameters mid-burst shows up as changed step spacing right after the ignored start pulse.

// File: rtl/sync_burst_gen.sv
module sync_burst_gen #(
  parameter int HALF_W  = 16,
  parameter int TOTAL_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [HALF_W-1:0]  half_ticks,
  input  logic [TOTAL_W-1:0] total_ticks,
  output logic               line_data,
  output logic               line_clk,
  output logic               busy,
  output logic               done
);

  localparam int EL_W = TOTAL_W + 2;

  logic               busy_q, done_q;
  logic [1:0]         phase_q;
  logic [HALF_W-1:0]  hcnt_q, half_q;
  logic [TOTAL_W-1:0] total_q;
  logic [EL_W-1:0]    elapsed_q;

  logic [HALF_W-1:0] half_eff;
  logic              step, budget_met, finish, launch;

  assign half_eff   = (half_ticks == '0) ? HALF_W'(1) : half_ticks;
  assign step       = (hcnt_q == half_q - HALF_W'(1));
  assign budget_met = (elapsed_q + EL_W'(1)) >= EL_W'(total_q);
  assign finish     = busy_q && step && (phase_q == 2'b11) && budget_met;
  assign launch     = start && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      phase_q   <= 2'b00;
      hcnt_q    <= '0;
      half_q    <= HALF_W'(1);
      total_q   <= '0;
      elapsed_q <= '0;
    end else begin
      done_q <= finish;
      if (launch) begin
        busy_q    <= 1'b1;
        phase_q   <= 2'b00;
        hcnt_q    <= '0;
        half_q    <= half_eff;
        total_q   <= total_ticks;
        elapsed_q <= '0;
      end else if (busy_q) begin
        elapsed_q <= elapsed_q + EL_W'(1);
        if (finish) begin
          busy_q  <= 1'b0;
          phase_q <= 2'b00;
          hcnt_q  <= '0;
        end else if (step) begin
          hcnt_q  <= '0;
          phase_q <= phase_q + 2'b01;
        end else begin
          hcnt_q <= hcnt_q + HALF_W'(1);
        end
      end
    end
  end

  assign line_data = busy_q ? phase_q[0] : 1'b1;
  assign line_clk  = busy_q ? phase_q[1] : 1'b1;
  assign busy      = busy_q;
  assign done      = done_q;

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (line_data && line_clk));

  p_first_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!line_data && !line_clk));

  p_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (line_clk != $past(line_clk))) |-> (line_data != $past(line_data)));

  p_end_full_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(line_clk) && $past(line_data) && done));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && line_data && line_clk));

  p_latched_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (half_q == $past(half_q) && total_q == $past(total_q)));

endmodule

// File: tb/sim_sync_burst_gen.sv
module sim_sync_burst_gen;
  localparam int HW = 16;
  localparam int TW = 32;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [HW-1:0] half_ticks = '0;
  logic [TW-1:0] total_ticks = '0;
  logic line_data, line_clk, busy, done;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sync_burst_gen #(.HALF_W(HW), .TOTAL_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .half_ticks(half_ticks),
    .total_ticks(total_ticks), .line_data(line_data), .line_clk(line_clk),
    .busy(busy), .done(done));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int eff_half(input int h);
    return (h == 0) ? 1 : h;
  endfunction

  function automatic int burst_len(input int h, input int total);
    int p = 4 * eff_half(h);
    int n = (total + p - 1) / p;
    if (n < 1) n = 1;
    return n * p;
  endfunction

  function automatic int exp_phase(input int h, input int k);
    return (k / eff_half(h)) % 4;
  endfunction

  task automatic run_burst(input int h, input int total, input bit poke);
    int len = burst_len(h, total);
    @(negedge clk);
    half_ticks  = HW'(h);
    total_ticks = TW'(total);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2 busy rises", int'(busy), 1);
    check({line_clk, line_data} === 2'b00, "R2 first lines low", int'({line_clk, line_data}), 0);
    for (int k = 0; k < len; k++) begin
      if (k > 0) @(negedge clk);
      check(busy === 1'b1 && done === 1'b0, "R6 busy through burst", int'({busy, done}), 2);
      check(int'({line_clk, line_data}) == exp_phase(h, k),
            (h == 0) ? "R5 zero half as one" : (poke ? "R8 ignored start" : "R3 pattern"),
            int'({line_clk, line_data}), exp_phase(h, k));
      if (poke && k == 2) begin
        start = 1'b1;
        half_ticks = HW'(eff_half(h) + 3);
        total_ticks = TW'(total + 40);
      end else if (poke && k == 3) begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b1, "R7 end pulse", int'({busy, done}), 1);
    check({line_clk, line_data} === 2'b11, "R7 lines released", int'({line_clk, line_data}), 3);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R1 idle after done", int'({busy, done}), 0);
    check({line_clk, line_data} === 2'b11, "R1 idle high", int'({line_clk, line_data}), 3);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run completion)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 reset state", int'({busy, done}), 0);
    check({line_clk, line_data} === 2'b11, "R1 reset lines", int'({line_clk, line_data}), 3);

    run_burst(1, 0, 1'b0);      // R6 zero budget -> one slow period
    run_burst(0, 5, 1'b0);      // R5 zero half count
    run_burst(2, 8, 1'b0);      // R6 exact multiple
    run_burst(2, 9, 1'b0);      // R6 rounds up to full period
    run_burst(3, 25, 1'b1);     // R8 start and parameter change mid-burst
    run_burst(5, 1, 1'b0);      // R3 wide half period

    for (int i = 0; i < 24; i++) begin
      int h = int'($urandom_range(0, 6));
      int t = int'($urandom_range(0, 90));
      run_burst(h, t, $urandom_range(0, 3) == 0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule